// File: doc/BRIEF.md
# Cartridge-Port Shadow SRAM Decoder

This block sits on the cartridge port of an 8-bit home computer. The port carries only the low fourteen CPU address bits. Some upper memory regions have no select line of their own. The block works out when the CPU is accessing one of them and steers that access to an external SRAM. It uses two kinds of evidence: bit A13 and the absence of any active block, RAM or I/O select from the host decoder. From these it places the cycle in the top 8 KB of the map, or in one of two 3 KB windows that are indistinguishable from each other.

When a cycle is a hit, the block drives a select line low while phase 2 is high. This cuts the internal memory off the data bus. During the same phase it strobes the SRAM chip-select, and then output-enable or write-enable according to R/W. A small control register is written by an IO3 write cycle and latched on the falling edge of phase 2. It switches each shadow region on or off and picks which 3 KB window the SRAM stands for. Reset clears the register, so the machine comes up with its normal memory map.

Top module: `shadow_sram_decoder`

## Requirements
- R1: After reset the control register is zero. No access produces an override or any SRAM strobe until the register is written.
- R2: Take a cycle with addr_i[13]=1, all nine sel_ni bits high and control bit 0 set. It is a top-region hit, and sram_addr_o = 14'h2000 | addr_i[12:0].
- R3: Take a cycle with addr_i in 14'h0400..14'h0FFF, all nine sel_ni bits high and control bit 1 set. It is a window hit. sram_addr_o = addr_i[11:0] when control bit 2 is 0, and sram_addr_o = 14'h1000 | addr_i[11:0] when control bit 2 is 1.
- R4: A cycle with any sel_ni bit low is never a hit. The sel_ni bit order is {io3, io2, ram3, ram2, ram1, blk5, blk3, blk2, blk1}, with blk1 at bit 0.
- R5: Low addresses 14'h1800..14'h1FFF are never a hit, because they alias the I/O range. Neither are 14'h0000..14'h03FF or 14'h1000..14'h17FF.
- R6: sel_ovr_oe_o is 1 only while phi2_i is high during a hit, and sel_ovr_o is always 0. Outside that phase the line is released.
- R7: On a hit with phi2_i high, sram_ce_no is 0. sram_oe_no is 0 only when rnw_i=1, and sram_we_no is 0 only when rnw_i=0. All three are 1 while phi2_i is low.
- R8: A region whose enable bit is clear produces no override and no strobes, even when its address and select conditions match.
- R9: The control register loads data_i[2:0] at the falling edge of phi2_i only when sel_ni[8] (io3) is low and rnw_i=0. An IO3 read leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phi2_i | input | 1 | Phase-2 clock of the CPU bus |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| addr_i | input | 14 | Visible address bits A13..A0 |
| sel_ni | input | 9 | Active-low host selects {io3,io2,ram3,ram2,ram1,blk5,blk3,blk2,blk1} |
| rnw_i | input | 1 | CPU read (1) / write (0) |
| data_i | input | 3 | Low data bits for control register writes |
| sel_ovr_oe_o | output | 1 | Drive enable for the select-line override |
| sel_ovr_o | output | 1 | Override value, constant low |
| sram_ce_no | output | 1 | SRAM chip-select, active low |
| sram_oe_no | output | 1 | SRAM output-enable, active low |
| sram_we_no | output | 1 | SRAM write-enable, active low |
| sram_addr_o | output | 14 | SRAM address |

## Verification
The only internal state is the control register. If it holds a wrong value, the error appears in the very next phase-2 high phase, and only on cycles that match a region's address and select conditions. There it shows as an override and strobes that are present when they should be absent, or the reverse, or as SRAM bit 12 landing in the wrong window. Each register write in the bench is therefore followed straight away by accesses to both regions and both windows. IO3 reads and other select-low cycles are placed between them, so that a spurious load or a missing load shows at the ports within one cycle.

// File: rtl/shadow_dec_pkg.sv
package shadow_dec_pkg;
  localparam int SEL_N     = 9;
  localparam int SEL_IO3   = 8;
  localparam int CB_TOP_EN = 0;
  localparam int CB_MID_EN = 1;
  localparam int CB_MID_HI = 2;

  typedef struct packed {
    logic top;
    logic mid;
  } hit_t;
endpackage

// File: rtl/shadow_ctrl_reg.sv
module shadow_ctrl_reg #(
  parameter int CTRL_W = 3,
  parameter int SEL_N  = 9,
  parameter int IO_BIT = 8
) (
  input  logic              phi2_i,
  input  logic              rst_ni,
  input  logic [SEL_N-1:0]  sel_ni,
  input  logic              rnw_i,
  input  logic [CTRL_W-1:0] data_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic wr_en;
  assign wr_en = ~sel_ni[IO_BIT] & ~rnw_i;

  // latch at the end of the bus cycle
  always_ff @(negedge phi2_i or negedge rst_ni) begin
    if (!rst_ni)    ctrl_o <= '0;
    else if (wr_en) ctrl_o <= data_i;
  end

  p_ctrl_load_r9: assert property (@(negedge phi2_i) disable iff (!rst_ni)
    wr_en |=> (ctrl_o == $past(data_i)));
  p_ctrl_hold_r9: assert property (@(negedge phi2_i) disable iff (!rst_ni)
    !wr_en |=> $stable(ctrl_o));
endmodule

// File: rtl/shadow_region_detect.sv
module shadow_region_detect
  import shadow_dec_pkg::*;
#(
  parameter int              ADDR_W = 14,
  parameter int              SEL_N  = 9,
  parameter logic [ADDR_W-1:0] MID_LO = 14'h0400,
  parameter logic [ADDR_W-1:0] MID_HI = 14'h0FFF,
  parameter logic [ADDR_W-1:0] IOA_LO = 14'h1800,
  parameter logic [ADDR_W-1:0] IOA_HI = 14'h1FFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SEL_N-1:0]  sel_ni,
  input  logic              top_en_i,
  input  logic              mid_en_i,
  output hit_t              hit_o
);
  logic quiet, in_mid;

  // no host select fired: access lies in a region without a select line
  assign quiet  = &sel_ni;
  assign in_mid = (addr_i >= MID_LO) && (addr_i <= MID_HI);

  always_comb begin
    hit_o.top = addr_i[ADDR_W-1] & quiet & top_en_i;
    hit_o.mid = in_mid & quiet & mid_en_i;
  end

  always_comb begin
    if (addr_i >= IOA_LO && addr_i <= IOA_HI)
      p_io_alias_r5: assert (!hit_o.top && !hit_o.mid);
    if (!quiet)
      p_sel_low_r4: assert (!hit_o.top && !hit_o.mid);
    p_hit_onehot_r3: assert (!(hit_o.top && hit_o.mid));
  end
endmodule

// File: rtl/shadow_strobe_gen.sv
module shadow_strobe_gen
  import shadow_dec_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              phi2_i,
  input  logic              rnw_i,
  input  hit_t              hit_i,
  input  logic              win_hi_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ovr_oe_o,
  output logic              ovr_o,
  output logic              ce_no,
  output logic              oe_no,
  output logic              we_no,
  output logic [ADDR_W-1:0] sram_addr_o
);
  logic act;
  assign act = (hit_i.top | hit_i.mid) & phi2_i;

  assign ovr_o    = 1'b0;
  assign ovr_oe_o = act;
  assign ce_no    = ~act;
  assign oe_no    = ~(act & rnw_i);
  assign we_no    = ~(act & ~rnw_i);

  // top region uses the upper SRAM half; window bit picks the 3 KB area
  assign sram_addr_o = {hit_i.top,
                        hit_i.mid ? win_hi_i : addr_i[ADDR_W-2],
                        addr_i[ADDR_W-3:0]};

  always_comb begin
    p_we_oe_excl_r7: assert (we_no | oe_no);
    if (!phi2_i)
      p_ovr_phase_r6: assert (!ovr_oe_o && ce_no && we_no && oe_no);
    if (!ce_no)
      p_ovr_with_ce_r6: assert (ovr_oe_o);
  end
endmodule

// File: rtl/shadow_sram_decoder.sv
module shadow_sram_decoder
  import shadow_dec_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int CTRL_W = 3
) (
  input  logic              phi2_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SEL_N-1:0]  sel_ni,
  input  logic              rnw_i,
  input  logic [CTRL_W-1:0] data_i,
  output logic              sel_ovr_oe_o,
  output logic              sel_ovr_o,
  output logic              sram_ce_no,
  output logic              sram_oe_no,
  output logic              sram_we_no,
  output logic [ADDR_W-1:0] sram_addr_o
);
  logic [CTRL_W-1:0] ctrl_q;
  hit_t              hit;

  shadow_ctrl_reg #(.CTRL_W(CTRL_W), .SEL_N(SEL_N), .IO_BIT(SEL_IO3)) u_ctrl (
    .phi2_i (phi2_i),
    .rst_ni (rst_ni),
    .sel_ni (sel_ni),
    .rnw_i  (rnw_i),
    .data_i (data_i),
    .ctrl_o (ctrl_q)
  );

  shadow_region_detect #(.ADDR_W(ADDR_W), .SEL_N(SEL_N)) u_detect (
    .addr_i   (addr_i),
    .sel_ni   (sel_ni),
    .top_en_i (ctrl_q[CB_TOP_EN]),
    .mid_en_i (ctrl_q[CB_MID_EN]),
    .hit_o    (hit)
  );

  shadow_strobe_gen #(.ADDR_W(ADDR_W)) u_strobe (
    .phi2_i      (phi2_i),
    .rnw_i       (rnw_i),
    .hit_i       (hit),
    .win_hi_i    (ctrl_q[CB_MID_HI]),
    .addr_i      (addr_i),
    .ovr_oe_o    (sel_ovr_oe_o),
    .ovr_o       (sel_ovr_o),
    .ce_no       (sram_ce_no),
    .oe_no       (sram_oe_no),
    .we_no       (sram_we_no),
    .sram_addr_o (sram_addr_o)
  );

  always_comb begin
    if (hit.top) p_top_needs_a13_r2: assert (addr_i[ADDR_W-1]);
    if (!ctrl_q[CB_TOP_EN]) p_top_off_r8: assert (!hit.top);
    if (!ctrl_q[CB_MID_EN]) p_mid_off_r8: assert (!hit.mid);
  end
endmodule

// File: tb/shadow_sram_decoder_tb.sv
module shadow_sram_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [13:0] addr = '0;
  logic [8:0]  sel = 9'h1FF;
  logic        rnw = 1'b1;
  logic [2:0]  data = '0;
  logic        ovr_oe, ovr, ce_n, oe_n, we_n;
  logic [13:0] saddr;
  logic [2:0]  ctrl_m = '0;
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  shadow_sram_decoder dut_i (
    .phi2_i(clk), .rst_ni(rst_ni), .addr_i(addr), .sel_ni(sel), .rnw_i(rnw),
    .data_i(data), .sel_ovr_oe_o(ovr_oe), .sel_ovr_o(ovr), .sram_ce_no(ce_n),
    .sram_oe_no(oe_n), .sram_we_no(we_n), .sram_addr_o(saddr)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one bus cycle: drive in low phase, check low phase, then high phase
  task automatic access(input logic [13:0] a, input logic [8:0] s, input logic r, input string req);
    logic quiet, top, mid, hit;
    logic [13:0] ea;
    @(negedge clk); #1;
    addr = a; sel = s; rnw = r;
    quiet = &s;
    top = a[13] & quiet & ctrl_m[0];
    mid = (a >= 14'h0400) && (a <= 14'h0FFF) && quiet && ctrl_m[1];
    hit = top | mid;
    ea  = top ? (14'h2000 | {1'b0, a[12:0]}) : ((ctrl_m[2] ? 14'h1000 : 14'h0000) | {2'b0, a[11:0]});
    #1;
    chk({req, " R6/R7 low phase"}, {12'b0, ovr_oe, ce_n, oe_n, we_n}, 16'h0007);
    @(posedge clk); #2;
    chk({req, " R6 ovr_oe"}, {15'b0, ovr_oe}, {15'b0, hit});
    chk({req, " R6 ovr value"}, {15'b0, ovr}, 16'h0);
    chk({req, " R7 strobes"}, {13'b0, ce_n, oe_n, we_n},
        {13'b0, ~hit, ~(hit & r), ~(hit & ~r)});
    if (hit) chk({req, " addr"}, {2'b0, saddr}, {2'b0, ea});
  endtask

  task automatic write_ctrl(input logic [2:0] v, input string req);
    @(negedge clk); #1;
    addr = 14'h1C00; sel = 9'h0FF; rnw = 1'b0; data = v;
    @(negedge clk);
    ctrl_m = v;
    #1; sel = 9'h1FF; rnw = 1'b1; data = ~v;
  endtask

  task automatic t_reset();
    access(14'h3000, 9'h1FF, 1'b1, "R1 top after reset");
    access(14'h0800, 9'h1FF, 1'b0, "R1 window after reset");
  endtask

  task automatic t_top();
    write_ctrl(3'b001, "R9");
    access(14'h2000, 9'h1FF, 1'b1, "R2 top read low edge");
    access(14'h3FFF, 9'h1FF, 1'b0, "R2 top write high edge");
    access(14'h2ABC, 9'h1FF, 1'b1, "R2 top read");
    access(14'h0800, 9'h1FF, 1'b1, "R8 window disabled");
  endtask

  task automatic t_mid();
    write_ctrl(3'b010, "R9");
    access(14'h0400, 9'h1FF, 1'b1, "R3 win lo start");
    access(14'h0FFF, 9'h1FF, 1'b0, "R3 win lo end");
    access(14'h03FF, 9'h1FF, 1'b1, "R5 below window");
    access(14'h1000, 9'h1FF, 1'b1, "R5 above window");
    access(14'h3000, 9'h1FF, 1'b1, "R8 top disabled");
    write_ctrl(3'b110, "R9");
    access(14'h0400, 9'h1FF, 1'b0, "R3 win hi start");
    access(14'h0C35, 9'h1FF, 1'b1, "R3 win hi mid");
  endtask

  task automatic t_sel_low();
    write_ctrl(3'b011, "R9");
    access(14'h0800, 9'h1FD, 1'b1, "R4 blk2 low alias");
    access(14'h0800, 9'h1EF, 1'b1, "R4 ram1 low");
    access(14'h0500, 9'h1BF, 1'b0, "R4 ram3 low");
    access(14'h2100, 9'h1FE, 1'b1, "R4 blk1 low");
    access(14'h2100, 9'h1FB, 1'b0, "R4 blk3 low");
    access(14'h3F00, 9'h1F7, 1'b1, "R4 blk5 low");
    access(14'h3F00, 9'h17F, 1'b1, "R4 io2 low");
  endtask

  task automatic t_io_alias();
    access(14'h1800, 9'h1FF, 1'b1, "R5 alias start");
    access(14'h1FFF, 9'h1FF, 1'b0, "R5 alias end");
    access(14'h1C44, 9'h1FF, 1'b1, "R5 alias mid");
  endtask

  task automatic t_io3_read();
    // IO3 read with data that would disable both regions must not load
    @(negedge clk); #1;
    addr = 14'h1C00; sel = 9'h0FF; rnw = 1'b1; data = 3'b000;
    @(negedge clk); #1;
    sel = 9'h1FF;
    access(14'h2222, 9'h1FF, 1'b1, "R9 io3 read keeps top");
    access(14'h0600, 9'h1FF, 1'b0, "R9 io3 read keeps window");
  endtask

  initial begin
    #10000000;
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_ni = 1'b1;
    t_reset();
    t_top();
    t_mid();
    t_sel_low();
    t_io_alias();
    t_io3_read();
    write_ctrl(3'b000, "R9");
    access(14'h3000, 9'h1FF, 1'b0, "R8 all disabled top");
    access(14'h0700, 9'h1FF, 1'b1, "R8 all disabled window");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule